// File: doc/BRIEF.md
# Trim Memory Programming Sequencer

This block is a host-side controller. It writes a wanted control word into the nonvolatile store of a capacitive trim element using as few program pulses as possible. The element is reached over three wires: a serial data line, a serial clock, and an enable that gates the external programming voltage. A fourth wire carries the read-back level into the block. Producing the programming voltage itself is outside this block.

After a start, the sequencer reads every stored bit back, one serial frame per bit. The store selects a bit for reading by a low on that bit's data position. The wanted word is inverted, because the store uses active-low selection, and the inverted word is then compared with the stored bits. Some bits may hold 0 where 1 is needed. Such a bit can only be set again by a whole-store erase, so in that case one erase frame is sent first. Then every bit that still holds 1 where 0 is needed receives its own frame and pulse, lowest position first. A last read-back pass checks the result and raises either done or error.

Every serial interval is a count of system-clock cycles set by a parameter. This lets one design run at production timing (a clock of at most 100 kHz, a 10 ms pulse, at least 4 µs of guard) and at a shortened test timing.

Top module: `trim_prog_seq`

## Requirements
- R1: Each read frame shifts WORD_W bits with the bit-0 value first. Only the selected position is low, so the frame word is all ones except that bit. One run sends WORD_W read frames before any programming and WORD_W read frames for the verify pass.
- R2: The target store image is the bitwise inverse of `desired`. Only positions that read as 1 but must become 0 are programmed, each by its own frame whose word is 0 at that position only and 1 elsewhere. The pulse count equals the number of such positions.
- R3: If any position reads 0 where the target needs 1, one erase frame (all ones) with a program pulse is sent before any single-bit write. No erase is sent otherwise.
- R4: `prog_data` changes only while `prog_clk` is low. Each clock half period lasts HALF_CYC cycles.
- R5: `prog_pulse` is high for exactly PULSE_CYC cycles, only while `prog_clk` is held high after a complete frame, with GAP_CYC high-clock cycles before and after it.
- R6: The read-back level is taken while `prog_clk` is high, at least SETTLE_CYC cycles after the frame's last rising clock edge.
- R7: After the verify pass, `done` goes high if every read bit equals the target image; otherwise `err` goes high. Both stay until the next accepted start and are never high together, and neither is high while `busy` is high.
- R8: A `start` pulse while `busy` is high is ignored. While not busy, `prog_clk` and `prog_pulse` stay low.
- R9: After reset, `prog_clk`, `prog_data`, `prog_pulse`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to program `desired` |
| desired | input | WORD_W | Wanted control word (1 = capacitor selected) |
| rdback | input | 1 | Read-back level from the store's program pin |
| prog_clk | output | 1 | Serial clock to the element |
| prog_data | output | 1 | Serial data to the element |
| prog_pulse | output | 1 | Enable for the programming-voltage pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run verified clean |
| err | output | 1 | Last run failed verify |

## Verification
On every cycle, the assertions check four things about the serial wires: data is held while the clock is high, the pulse occurs only with the clock high and lasts exactly its programmed count, the wires are quiet when the block is idle, and the status flags exclude each other. Other behaviour depends on what the store holds, and only the bench scenarios can show it. These are: choosing which positions to write, when an erase is needed, the order of erase before writes, the frame and pulse counts, and the verify result. For that, a behavioural store model answers read frames and applies pulses, with one scenario using a bit that cannot be programmed.

// File: rtl/trim_prog_seq_pkg.sv
package trim_prog_seq_pkg;

  typedef enum logic [2:0] {
    F_IDLE, F_LOW, F_HIGH, F_SETTLE, F_GAP1, F_PULSE, F_GAP2, F_END
  } frame_st_t;

  typedef enum logic [2:0] {
    C_IDLE, C_RD, C_EVAL, C_ER, C_WSEL, C_WR, C_VF, C_FIN
  } ctrl_st_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/trim_frame_tx.sv
module trim_frame_tx
  import trim_prog_seq_pkg::*;
#(
  parameter int WORD_W     = 11,
  parameter int HALF_CYC   = 250,
  parameter int SETTLE_CYC = 100,
  parameter int GAP_CYC    = 200,
  parameter int PULSE_CYC  = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              f_start,
  input  logic [WORD_W-1:0] f_word,
  input  logic              f_read,
  input  logic              rd_level,
  output logic              f_done,
  output logic              f_bit,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              pgm_en
);
  localparam int MAXC = max_of4(HALF_CYC, SETTLE_CYC, GAP_CYC, PULSE_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int IW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  frame_st_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] word_q;
  logic              read_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= F_IDLE;
      cnt      <= '0;
      idx      <= '0;
      word_q   <= '0;
      read_q   <= 1'b0;
      f_done   <= 1'b0;
      f_bit    <= 1'b0;
      ser_clk  <= 1'b0;
      ser_data <= 1'b0;
      pgm_en   <= 1'b0;
    end else begin
      f_done <= 1'b0;
      case (st)
        F_IDLE: if (f_start) begin
          word_q   <= f_word;
          read_q   <= f_read;
          idx      <= '0;
          ser_data <= f_word[0];
          ser_clk  <= 1'b0;
          cnt      <= CW'(HALF_CYC - 1);
          st       <= F_LOW;
        end
        F_LOW: begin
          if (cnt == '0) begin
            ser_clk <= 1'b1;
            cnt     <= CW'(HALF_CYC - 1);
            st      <= F_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        F_HIGH: begin
          if (cnt == '0) begin
            if (idx == IW'(WORD_W - 1)) begin
              if (read_q) begin
                cnt <= CW'(SETTLE_CYC - 1);
                st  <= F_SETTLE;
              end else begin
                cnt <= CW'(GAP_CYC - 1);
                st  <= F_GAP1;
              end
            end else begin
              idx      <= idx + 1'b1;
              ser_data <= word_q[idx + 1'b1];
              ser_clk  <= 1'b0;
              cnt      <= CW'(HALF_CYC - 1);
              st       <= F_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        F_SETTLE: begin
          if (cnt == '0) begin
            f_bit    <= rd_level;
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            cnt      <= CW'(HALF_CYC - 1);
            st       <= F_END;
          end else cnt <= cnt - 1'b1;
        end
        F_GAP1: begin
          if (cnt == '0) begin
            pgm_en <= 1'b1;
            cnt    <= CW'(PULSE_CYC - 1);
            st     <= F_PULSE;
          end else cnt <= cnt - 1'b1;
        end
        F_PULSE: begin
          if (cnt == '0) begin
            pgm_en <= 1'b0;
            cnt    <= CW'(GAP_CYC - 1);
            st     <= F_GAP2;
          end else cnt <= cnt - 1'b1;
        end
        F_GAP2: begin
          if (cnt == '0) begin
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            cnt      <= CW'(HALF_CYC - 1);
            st       <= F_END;
          end else cnt <= cnt - 1'b1;
        end
        F_END: begin
          if (cnt == '0) begin
            f_done <= 1'b1;
            st     <= F_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_lsb_pick.sv
module trim_lsb_pick #(
  parameter int WORD_W = 11
) (
  input  logic [WORD_W-1:0] req,
  output logic [WORD_W-1:0] grant
);
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < WORD_W; i++) begin
      grant[i] = req[i] & ~seen;
      seen     = seen | req[i];
    end
  end
endmodule

// File: rtl/trim_seq_ctrl.sv
module trim_seq_ctrl
  import trim_prog_seq_pkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] desired,
  input  logic              f_done,
  input  logic              f_bit,
  output logic              f_start,
  output logic [WORD_W-1:0] f_word,
  output logic              f_read,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  ctrl_st_t          st;
  logic [WORD_W-1:0] target, stored, sel;
  logic [IW-1:0]     idx;
  logic              vf_bad;
  logic [WORD_W-1:0] pend, grant;
  logic              need_erase;
  logic              last_idx;

  assign pend       = stored & ~target;
  assign need_erase = |(target & ~stored);
  assign last_idx   = (idx == IW'(WORD_W - 1));

  trim_lsb_pick #(.WORD_W(WORD_W)) u_pick (
    .req   (pend),
    .grant (grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= C_IDLE;
      target  <= '0;
      stored  <= '0;
      sel     <= '0;
      idx     <= '0;
      vf_bad  <= 1'b0;
      f_start <= 1'b0;
      f_word  <= '0;
      f_read  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      f_start <= 1'b0;
      case (st)
        C_IDLE: if (start) begin
          target  <= ~desired;
          stored  <= '0;
          idx     <= '0;
          busy    <= 1'b1;
          done    <= 1'b0;
          err     <= 1'b0;
          f_start <= 1'b1;
          f_word  <= ~ONE;
          f_read  <= 1'b1;
          st      <= C_RD;
        end
        C_RD: if (f_done) begin
          stored[idx] <= f_bit;
          if (last_idx) st <= C_EVAL;
          else begin
            idx     <= idx + 1'b1;
            f_start <= 1'b1;
            f_word  <= ~(ONE << (idx + 1'b1));
            f_read  <= 1'b1;
          end
        end
        C_EVAL: begin
          if (need_erase) begin
            f_start <= 1'b1;
            f_word  <= '1;
            f_read  <= 1'b0;
            st      <= C_ER;
          end else st <= C_WSEL;
        end
        C_ER: if (f_done) begin
          stored <= '1;
          st     <= C_WSEL;
        end
        C_WSEL: begin
          f_start <= 1'b1;
          if (|pend) begin
            sel    <= grant;
            f_word <= ~grant;
            f_read <= 1'b0;
            st     <= C_WR;
          end else begin
            idx    <= '0;
            vf_bad <= 1'b0;
            f_word <= ~ONE;
            f_read <= 1'b1;
            st     <= C_VF;
          end
        end
        C_WR: if (f_done) begin
          stored <= stored & ~sel;
          st     <= C_WSEL;
        end
        C_VF: if (f_done) begin
          if (f_bit != target[idx]) vf_bad <= 1'b1;
          if (last_idx) st <= C_FIN;
          else begin
            idx     <= idx + 1'b1;
            f_start <= 1'b1;
            f_word  <= ~(ONE << (idx + 1'b1));
            f_read  <= 1'b1;
          end
        end
        C_FIN: begin
          busy <= 1'b0;
          done <= ~vf_bad;
          err  <= vf_bad;
          st   <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_prog_seq.sv
module trim_prog_seq #(
  parameter int WORD_W     = 11,
  parameter int HALF_CYC   = 250,
  parameter int SETTLE_CYC = 100,
  parameter int GAP_CYC    = 200,
  parameter int PULSE_CYC  = 500000,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] desired,
  input  logic              rdback,
  output logic              prog_clk,
  output logic              prog_data,
  output logic              prog_pulse,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [SYNC_STG-1:0] rd_sync;
  logic                f_start, f_read, f_done, f_bit;
  logic [WORD_W-1:0]   f_word;

  generate
    if (SYNC_STG == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) rd_sync <= '0;
        else     rd_sync <= rdback;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) rd_sync <= '0;
        else     rd_sync <= {rd_sync[SYNC_STG-2:0], rdback};
      end
    end
  endgenerate

  trim_seq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .desired (desired),
    .f_done  (f_done),
    .f_bit   (f_bit),
    .f_start (f_start),
    .f_word  (f_word),
    .f_read  (f_read),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  trim_frame_tx #(
    .WORD_W     (WORD_W),
    .HALF_CYC   (HALF_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .GAP_CYC    (GAP_CYC),
    .PULSE_CYC  (PULSE_CYC)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .f_start  (f_start),
    .f_word   (f_word),
    .f_read   (f_read),
    .rd_level (rd_sync[SYNC_STG-1]),
    .f_done   (f_done),
    .f_bit    (f_bit),
    .ser_clk  (prog_clk),
    .ser_data (prog_data),
    .pgm_en   (prog_pulse)
  );
endmodule

// File: rtl/trim_prog_seq_chk.sv
module trim_prog_seq_chk #(
  parameter int PULSE_CYC = 500000
) (
  input logic clk,
  input logic rst,
  input logic prog_clk,
  input logic prog_data,
  input logic prog_pulse,
  input logic busy,
  input logic done,
  input logic err
);
  logic [31:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst)             pcnt <= '0;
    else if (prog_pulse) pcnt <= pcnt + 1'b1;
    else                 pcnt <= '0;
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (prog_clk && $past(prog_clk)) |-> $stable(prog_data)); // R4
  AST_PULSE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    prog_pulse |-> prog_clk); // R5
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_pulse) |-> (pcnt == 32'(PULSE_CYC))); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!prog_clk && !prog_pulse)); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err) && !(busy && (done || err))); // R7
endmodule

bind trim_prog_seq trim_prog_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .prog_clk   (prog_clk),
  .prog_data  (prog_data),
  .prog_pulse (prog_pulse),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/trim_prog_seq_bench.sv
`timescale 1ns/1ps
module trim_prog_seq_bench;
  localparam int W      = 11;
  localparam int HALF   = 4;
  localparam int SETTLE = 6;
  localparam int GAP    = 3;
  localparam int PULSE  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] desired = '0;
  logic rdback;
  logic prog_clk, prog_data, prog_pulse, busy, done, err;

  always #4 clk = ~clk;

  trim_prog_seq #(
    .WORD_W(W), .HALF_CYC(HALF), .SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .PULSE_CYC(PULSE)
  ) u_trim_prog_seq (
    .clk(clk), .rst(rst), .start(start), .desired(desired), .rdback(rdback),
    .prog_clk(prog_clk), .prog_data(prog_data), .prog_pulse(prog_pulse),
    .busy(busy), .done(done), .err(err)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // store model
  logic [W-1:0] store = '1;
  logic [W-1:0] stuck = '0;
  logic [W-1:0] sr = '1;
  logic [W-1:0] wmask = '0;
  logic [W-1:0] first_word = '0;
  int rises = 0, writes = 0, erases = 0, badframes = 0, pulses = 0;
  int hc = 0, plen = 0, last_plen = 0;

  function automatic int zero_pos(input logic [W-1:0] v);
    int n = 0;
    int p = -1;
    for (int i = 0; i < W; i++) if (!v[i]) begin n++; p = i; end
    return (n == 1) ? p : -1;
  endfunction

  always @(posedge prog_clk) begin
    sr = {prog_data, sr[W-1:1]};
    rises++;
  end

  always @(posedge prog_pulse) begin
    int p;
    p = zero_pos(sr);
    if (pulses == 0) first_word = sr;
    pulses++;
    if (sr == '1) begin store = '1; erases++; end
    else if (p >= 0) begin
      if (!stuck[p]) store[p] = 1'b0;
      writes++;
      wmask[p] = 1'b1;
    end else badframes++;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    hc  <= prog_clk ? hc + 1 : 0;
    if (prog_pulse) plen <= plen + 1;
    else if (plen != 0) begin last_plen <= plen; plen <= 0; end
  end

  // valid level only after the clock has been high SETTLE cycles, wrong level before
  always_comb begin
    int p;
    p = zero_pos(sr);
    if (p < 0) rdback = 1'b0;
    else rdback = (hc >= SETTLE) ? store[p] : ~store[p];
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    rises = 0; writes = 0; erases = 0; badframes = 0; pulses = 0; wmask = '0;
  endtask

  task automatic kick(input logic [W-1:0] d);
    @(negedge clk);
    desired = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || err) && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!prog_clk && !prog_data && !prog_pulse, "R9 serial lines", {prog_clk, prog_data, prog_pulse}, 0);
    chk(!busy, "R9 busy", busy, 0);
    chk(!done, "R9 done", done, 0);
    chk(!err, "R9 err", err, 0);
  endtask

  task automatic t_worked();
    store = '1; stuck = '0; clear_model();
    kick(11'h014);
    wait_end();
    chk(writes == 2, "R2 write count", writes, 2);
    chk(wmask == 11'h014, "R2 written bits", wmask, 11'h014);
    chk(erases == 0, "R3 no erase", erases, 0);
    chk(store == 11'h7EB, "R2 store image", store, 11'h7EB);
    chk(rises == 24 * W, "R1 frame bit count", rises, 24 * W);
    chk(badframes == 0, "R1 frame shape", badframes, 0);
    chk(last_plen == PULSE, "R5 pulse length", last_plen, PULSE);
    chk(done && !err, "R7 done clean", {done, err}, 2);
    chk(!busy, "R8 idle after", busy, 0);
  endtask

  task automatic t_erase();
    store = 11'h7EB; stuck = '0; clear_model();
    kick(11'h003);
    wait_end();
    chk(erases == 1, "R3 erase count", erases, 1);
    chk(first_word == '1, "R3 erase first", first_word, 11'h7FF);
    chk(writes == 2 && wmask == 11'h003, "R2 writes after erase", wmask, 11'h003);
    chk(store == 11'h7FC, "R3 store image", store, 11'h7FC);
    chk(done && !err, "R6 read-back correct", {done, err}, 2);
  endtask

  task automatic t_nochange();
    store = 11'h7FC; stuck = '0; clear_model();
    kick(11'h003);
    wait_end();
    chk(writes == 0 && erases == 0, "R2 nothing to write", pulses, 0);
    chk(rises == 22 * W, "R1 read frames only", rises, 22 * W);
    chk(done, "R7 done", done, 1);
  endtask

  task automatic t_fail();
    store = '1; stuck = 11'h020; clear_model();
    kick(11'h020);
    wait_end();
    chk(writes == 1, "R2 single attempt", writes, 1);
    chk(err && !done, "R7 error flag", {done, err}, 1);
    stuck = '0;
  endtask

  task automatic t_busy();
    store = '1; stuck = '0; clear_model();
    kick(11'h014);
    repeat (50) @(negedge clk);
    kick(11'h7FF);
    wait_end();
    chk(store == 11'h7EB, "R8 second start ignored", store, 11'h7EB);
    chk(writes == 2, "R8 write count", writes, 2);
    chk(done, "R8 done", done, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_worked();
    t_erase();
    t_nochange();
    t_fail();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule